// File: doc/BRIEF.md
# Software Standby Wake Controller

This block sequences a small processor system into and out of a deep power-down state. The CPU pulses a sleep strobe. If the standby-enable control bit is set at that moment, the controller enters standby. It stops the oscillator and gates both the CPU and peripheral clocks. It holds the serial-class peripherals in reset and sets the bus output policy. If the standby-enable bit is clear, the strobe only raises a light-sleep status flag and the clocks keep running.

In standby the controller watches several wake sources:

- the non-maskable interrupt;
- sixteen interrupt request lines, each qualified by its own enables, the CPU mask and the transfer-controller routing;
- a USB resume event;
- the active-low reset and hardware-standby pins.

An interrupt-class wake restarts the oscillator at once. The clocks stay gated until a programmable settling interval has passed on the always-on clock. The block then pulses an interrupt exception request. The reset pin brings the clocks back with no settling wait and requests reset handling when the pin is released. The hardware-standby pin overrides every other input.

Top module: `stby_wake_ctrl`

## Requirements
- R1: In RUN, a `sleep_strobe` with `stby_en`=1 moves the block to STANDBY on the next clock edge. `osc_en`, `cpu_clk_en` and `per_clk_en` are then all 0.
- R2: In RUN, a `sleep_strobe` with `stby_en`=0 leaves the state in RUN with all clocks enabled and sets `sleep_flag` on the next edge. The flag clears on the edge after an NMI, a USB resume, or an IRQ line whose `irq_en` bit is 1 and whose `irq_cpu_mask` bit is 0.
- R3: `per_srst` is 3 bits wide: bit 0 is the asynchronous serial unit, bit 1 the I2C unit and bit 2 the synchronous serial unit. All three bits are 1 in STANDBY, SETTLE, RESET_HOLD and HW_STANDBY, and all are 0 in RUN and WAKE_IRQ.
- R4: In STANDBY and SETTLE, `bus_hiz` equals the inverse of `bus_hold_en`. In HW_STANDBY `bus_hiz` is 1, and in every other state it is 0.
- R5: IRQ line n wakes the block from STANDBY only when `irq[n]`, `irq_en[n]` and `irq_stby_clr_en[n]` are all 1 and `irq_cpu_mask[n]` and `irq_dtc_route[n]` are both 0. Any other combination leaves the block in STANDBY.
- R6: `nmi` or `usb_resume` high in STANDBY starts a wake on the next edge, independent of the IRQ controls.
- R7: After a wake the block is in SETTLE from the next edge, with `osc_en`=1 and `cpu_clk_en`=0. It stays in SETTLE for exactly 2^(`settle_sel`+6) clock cycles, where `settle_sel` is the value sampled in the wake cycle.
- R8: When settling ends, the block spends one cycle in WAKE_IRQ with `irq_exc_req`=1 and clocks enabled, then returns to RUN with `irq_exc_req`=0.
- R9: `res_pin_n`=0 in any state other than HW_STANDBY moves the block to RESET_HOLD on the next edge. In RESET_HOLD `osc_en`, `cpu_clk_en` and `per_clk_en` are 1 with no settling wait, and the block stays there while the pin is low.
- R10: When `res_pin_n` is 1 in RESET_HOLD, the block returns to RUN on the next edge and `rst_exc_req` is 1 for exactly that first RUN cycle.
- R11: `hwstby_n`=0 moves the block to HW_STANDBY on the next edge from any state, overriding the reset pin and all wake sources. All clocks and the oscillator are off in HW_STANDBY.
- R12: Leaving HW_STANDBY when `hwstby_n` goes to 1 always passes through RESET_HOLD. RUN is reached only once `res_pin_n` is also 1, and the reset request of R10 is issued then.
- R13: `state_o` encodes RUN=0, STANDBY=1, SETTLE=2, WAKE_IRQ=3, RESET_HOLD=4, HW_STANDBY=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Free-running always-on clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_strobe | input | 1 | One-cycle pulse from the CPU sleep instruction |
| stby_en | input | 1 | Selects standby (1) or light sleep (0) on a sleep strobe |
| bus_hold_en | input | 1 | 1 keeps bus outputs driven in standby; 0 floats them |
| settle_sel | input | 4 | Settling time code, 2^(code+6) cycles |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 16 | Interrupt request lines |
| irq_en | input | 16 | Normal interrupt enable per line |
| irq_stby_clr_en | input | 16 | Standby-clear enable per line |
| irq_cpu_mask | input | 16 | CPU-side mask per line, 1 blocks |
| irq_dtc_route | input | 16 | 1 when the line activates the transfer controller |
| usb_resume | input | 1 | Resume event from the USB function |
| res_pin_n | input | 1 | Reset pin, active low |
| hwstby_n | input | 1 | Hardware-standby pin, active low |
| state_o | output | 3 | Current power state code |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_srst | output | 3 | Reset to serial, I2C and synchronous-serial units |
| bus_hiz | output | 1 | Floats address bus and bus control outputs |
| sleep_flag | output | 1 | Light-sleep status |
| irq_exc_req | output | 1 | Interrupt exception request pulse |
| rst_exc_req | output | 1 | Reset exception request pulse |

## Verification
A wrong state register shows at the ports one cycle after the edge that set it. Every clock enable, the peripheral reset and the bus policy are decoded straight from the state, so a wrongly entered or missed state flips at least one of them on the next sample. A settle counter with the wrong limit or the wrong increment changes the number of cycles with the oscillator on and the CPU clock off. The bench catches this as an exact cycle count that differs from 2^(code+6) for three codes. A wrongly qualified IRQ shows as a premature move to SETTLE, or a missing one, on the cycle after the line is raised.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;

   typedef enum logic [2:0] {
      PS_RUN        = 3'd0,
      PS_STANDBY    = 3'd1,
      PS_SETTLE     = 3'd2,
      PS_WAKE_IRQ   = 3'd3,
      PS_RESET_HOLD = 3'd4,
      PS_HW_STANDBY = 3'd5
   } pwr_state_e;

endpackage

// File: rtl/irq_wake_qual.sv
module irq_wake_qual #(
   parameter int N_IRQ = 16
) (
   input  logic [N_IRQ-1:0] irq,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic [N_IRQ-1:0] irq_stby_clr_en,
   input  logic [N_IRQ-1:0] irq_cpu_mask,
   input  logic [N_IRQ-1:0] irq_dtc_route,
   output logic             stby_wake,
   output logic             int_pending
);

   initial begin : p_param_chk
      assert (N_IRQ >= 1 && N_IRQ <= 32)
         else $error("irq_wake_qual: N_IRQ out of range");
   end

   logic [N_IRQ-1:0] line_wake;
   logic [N_IRQ-1:0] line_int;

   for (genvar n = 0; n < N_IRQ; n++) begin : g_line
      // a line that feeds the transfer controller never reaches the CPU
      assign line_wake[n] = irq[n] & irq_en[n] & irq_stby_clr_en[n]
                          & ~irq_cpu_mask[n] & ~irq_dtc_route[n];
      assign line_int[n]  = irq[n] & irq_en[n] & ~irq_cpu_mask[n];
   end

   assign stby_wake   = |line_wake;
   assign int_pending = |line_int;

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int SEL_W    = 4,
   parameter int BASE_EXP = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic [SEL_W-1:0] sel,
   output logic             done
);

   localparam int MAX_EXP = BASE_EXP + (1 << SEL_W) - 1;
   localparam int CNT_W   = MAX_EXP + 1;

   initial begin : p_param_chk
      assert (SEL_W >= 1 && BASE_EXP >= 1 && MAX_EXP <= 30)
         else $error("settle_timer: settle range too wide");
   end

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last = (CNT_W'(1) << (BASE_EXP + int'(sel_q))) - CNT_W'(1);
   assign done = active && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         cnt   <= '0;
      end else if (start) begin
         sel_q <= sel;
         cnt   <= '0;
      end else if (active && !done) begin
         cnt   <= cnt + CNT_W'(1);
      end
   end

   // R7
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !done && !start) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // R7
   cnt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == '0));

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
   import stby_wake_pkg::*;
#(
   parameter int N_SRST = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_strobe,
   input  logic              stby_en,
   input  logic              bus_hold_en,
   input  logic              wake_any,
   input  logic              int_any,
   input  logic              res_pin_n,
   input  logic              hwstby_n,
   input  logic              settle_done,
   output logic              settle_start,
   output logic              settle_active,
   output pwr_state_e        state,
   output logic              osc_en,
   output logic              cpu_clk_en,
   output logic              per_clk_en,
   output logic [N_SRST-1:0] per_srst,
   output logic              bus_hiz,
   output logic              sleep_flag,
   output logic              irq_exc_req,
   output logic              rst_exc_req
);

   initial begin : p_param_chk
      assert (N_SRST >= 1) else $error("pwr_fsm: N_SRST must be positive");
   end

   pwr_state_e nxt;
   logic       clocks_on;
   logic       rst_req_q;

   always_comb begin
      nxt          = state;
      settle_start = 1'b0;
      if (!hwstby_n) begin
         nxt = PS_HW_STANDBY;
      end else begin
         unique case (state)
            PS_RUN:
               if (!res_pin_n)                   nxt = PS_RESET_HOLD;
               else if (sleep_strobe && stby_en) nxt = PS_STANDBY;
            PS_STANDBY:
               if (!res_pin_n) nxt = PS_RESET_HOLD;
               else if (wake_any) begin
                  nxt          = PS_SETTLE;
                  settle_start = 1'b1;
               end
            PS_SETTLE:
               if (!res_pin_n)       nxt = PS_RESET_HOLD;
               else if (settle_done) nxt = PS_WAKE_IRQ;
            PS_WAKE_IRQ:
               nxt = res_pin_n ? PS_RUN : PS_RESET_HOLD;
            PS_RESET_HOLD:
               if (res_pin_n) nxt = PS_RUN;
            PS_HW_STANDBY:
               nxt = PS_RESET_HOLD;
            default:
               nxt = PS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PS_RUN;
         rst_req_q  <= 1'b0;
         sleep_flag <= 1'b0;
      end else begin
         state     <= nxt;
         rst_req_q <= (state == PS_RESET_HOLD) && res_pin_n && hwstby_n;
         if (state != PS_RUN || int_any)
            sleep_flag <= 1'b0;
         else if (sleep_strobe && !stby_en)
            sleep_flag <= 1'b1;
      end
   end

   assign clocks_on     = (state == PS_RUN) || (state == PS_WAKE_IRQ)
                       || (state == PS_RESET_HOLD);
   assign osc_en        = clocks_on || (state == PS_SETTLE);
   assign cpu_clk_en    = clocks_on;
   assign per_clk_en    = clocks_on;
   assign per_srst      = {N_SRST{(state != PS_RUN) && (state != PS_WAKE_IRQ)}};
   assign bus_hiz       = (state == PS_HW_STANDBY)
                       || (((state == PS_STANDBY) || (state == PS_SETTLE)) && !bus_hold_en);
   assign settle_active = (state == PS_SETTLE);
   assign irq_exc_req   = (state == PS_WAKE_IRQ);
   assign rst_exc_req   = rst_req_q;

   // R11
   hw_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hwstby_n |=> (state == PS_HW_STANDBY) && !osc_en);

   // R1
   enter_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RUN && sleep_strobe && stby_en && res_pin_n && hwstby_n)
      |=> (!osc_en && !cpu_clk_en && !per_clk_en));

   // R2
   light_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RUN && sleep_strobe && !stby_en && !int_any && res_pin_n && hwstby_n)
      |=> (state == PS_RUN && sleep_flag && cpu_clk_en));

   // R5
   stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_STANDBY && !wake_any && res_pin_n && hwstby_n)
      |=> (state == PS_STANDBY));

   // R8
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_exc_req |=> !irq_exc_req);

   // R10
   rst_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_exc_req) |-> ($past(state) == PS_RESET_HOLD) && (state == PS_RUN));

   // R12
   hw_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_HW_STANDBY && hwstby_n) |=> (state == PS_RESET_HOLD));

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
   import stby_wake_pkg::*;
#(
   parameter int N_IRQ    = 16,
   parameter int SEL_W    = 4,
   parameter int BASE_EXP = 6,
   parameter int N_SRST   = 3
) (
   input  logic              clk_aon,
   input  logic              rst_n,
   input  logic              sleep_strobe,
   input  logic              stby_en,
   input  logic              bus_hold_en,
   input  logic [SEL_W-1:0]  settle_sel,
   input  logic              nmi,
   input  logic [N_IRQ-1:0]  irq,
   input  logic [N_IRQ-1:0]  irq_en,
   input  logic [N_IRQ-1:0]  irq_stby_clr_en,
   input  logic [N_IRQ-1:0]  irq_cpu_mask,
   input  logic [N_IRQ-1:0]  irq_dtc_route,
   input  logic              usb_resume,
   input  logic              res_pin_n,
   input  logic              hwstby_n,
   output logic [2:0]        state_o,
   output logic              osc_en,
   output logic              cpu_clk_en,
   output logic              per_clk_en,
   output logic [N_SRST-1:0] per_srst,
   output logic              bus_hiz,
   output logic              sleep_flag,
   output logic              irq_exc_req,
   output logic              rst_exc_req
);

   logic       irq_wake;
   logic       irq_int;
   logic       wake_any;
   logic       int_any;
   logic       settle_start;
   logic       settle_active;
   logic       settle_done;
   pwr_state_e state;

   irq_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
      .irq             (irq),
      .irq_en          (irq_en),
      .irq_stby_clr_en (irq_stby_clr_en),
      .irq_cpu_mask    (irq_cpu_mask),
      .irq_dtc_route   (irq_dtc_route),
      .stby_wake       (irq_wake),
      .int_pending     (irq_int)
   );

   assign wake_any = irq_wake | nmi | usb_resume;
   assign int_any  = irq_int  | nmi | usb_resume;

   settle_timer #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_settle (
      .clk    (clk_aon),
      .rst_n  (rst_n),
      .start  (settle_start),
      .active (settle_active),
      .sel    (settle_sel),
      .done   (settle_done)
   );

   pwr_fsm #(.N_SRST(N_SRST)) u_fsm (
      .clk           (clk_aon),
      .rst_n         (rst_n),
      .sleep_strobe  (sleep_strobe),
      .stby_en       (stby_en),
      .bus_hold_en   (bus_hold_en),
      .wake_any      (wake_any),
      .int_any       (int_any),
      .res_pin_n     (res_pin_n),
      .hwstby_n      (hwstby_n),
      .settle_done   (settle_done),
      .settle_start  (settle_start),
      .settle_active (settle_active),
      .state         (state),
      .osc_en        (osc_en),
      .cpu_clk_en    (cpu_clk_en),
      .per_clk_en    (per_clk_en),
      .per_srst      (per_srst),
      .bus_hiz       (bus_hiz),
      .sleep_flag    (sleep_flag),
      .irq_exc_req   (irq_exc_req),
      .rst_exc_req   (rst_exc_req)
   );

   assign state_o = state;

   // R6
   wake_go_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
      (state == PS_STANDBY && (nmi || usb_resume) && res_pin_n && hwstby_n)
      |=> (state == PS_SETTLE) && osc_en && !cpu_clk_en);

endmodule

// File: tb/test_stby_wake_ctrl.sv
module test_stby_wake_ctrl;

   logic        clk_aon = 1'b0;
   logic        rst_n   = 1'b0;
   logic        sleep_strobe = 1'b0;
   logic        stby_en = 1'b0;
   logic        bus_hold_en = 1'b0;
   logic [3:0]  settle_sel = 4'd0;
   logic        nmi = 1'b0;
   logic [15:0] irq = '0;
   logic [15:0] irq_en = '1;
   logic [15:0] irq_stby_clr_en = '1;
   logic [15:0] irq_cpu_mask = '0;
   logic [15:0] irq_dtc_route = '0;
   logic        usb_resume = 1'b0;
   logic        res_pin_n = 1'b1;
   logic        hwstby_n = 1'b1;
   logic [2:0]  state_o;
   logic        osc_en, cpu_clk_en, per_clk_en, bus_hiz, sleep_flag;
   logic        irq_exc_req, rst_exc_req;
   logic [2:0]  per_srst;

   int vectors = 0;
   int misses  = 0;
   bit finished = 1'b0;

   always #4 clk_aon = ~clk_aon;

   stby_wake_ctrl i_stby_wake_ctrl (
      .clk_aon(clk_aon), .rst_n(rst_n), .sleep_strobe(sleep_strobe),
      .stby_en(stby_en), .bus_hold_en(bus_hold_en), .settle_sel(settle_sel),
      .nmi(nmi), .irq(irq), .irq_en(irq_en), .irq_stby_clr_en(irq_stby_clr_en),
      .irq_cpu_mask(irq_cpu_mask), .irq_dtc_route(irq_dtc_route),
      .usb_resume(usb_resume), .res_pin_n(res_pin_n), .hwstby_n(hwstby_n),
      .state_o(state_o), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .per_srst(per_srst), .bus_hiz(bus_hiz),
      .sleep_flag(sleep_flag), .irq_exc_req(irq_exc_req), .rst_exc_req(rst_exc_req)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk_aon);
   endtask

   task automatic enter_standby();
      sleep_strobe = 1'b1; stby_en = 1'b1;
      tick();
      sleep_strobe = 1'b0;
      chk("R1", "state after strobe", 32'(state_o), 32'd1);
      chk("R1", "clocks off", {osc_en, cpu_clk_en, per_clk_en}, 3'b000);
   endtask

   task automatic run_settle(input int code);
      int n = 0;
      chk("R7", "osc on clk off", {osc_en, cpu_clk_en}, 2'b10);
      while (state_o == 3'd2 && n < 70000) begin
         n++;
         tick();
      end
      chk("R7", "settle cycles", n, 32'd1 << (code + 6));
      chk("R8", "wake state", 32'(state_o), 32'd3);
      chk("R8", "irq req and clocks", {irq_exc_req, cpu_clk_en, per_srst}, 5'b11000);
      tick();
      chk("R8", "back to run", {29'(state_o), irq_exc_req}, 32'd0 << 1);
   endtask

   task automatic t_reset();
      chk("R13", "reset state", 32'(state_o), 32'd0);
      chk("R3", "reset outputs", {osc_en, cpu_clk_en, per_clk_en, per_srst, bus_hiz},
          7'b1110000);
      chk("R2", "reset flags", {sleep_flag, irq_exc_req, rst_exc_req}, 3'b000);
   endtask

   task automatic t_light_sleep();
      sleep_strobe = 1'b1; stby_en = 1'b0;
      tick();
      sleep_strobe = 1'b0;
      chk("R2", "stay run", 32'(state_o), 32'd0);
      chk("R2", "flag and clocks", {sleep_flag, cpu_clk_en, per_clk_en, osc_en}, 4'b1111);
      tick();
      chk("R2", "flag holds", 32'(sleep_flag), 32'd1);
      // IRQ without CPU-side enable must not clear the flag
      irq_en[2] = 1'b0; irq[2] = 1'b1;
      tick();
      chk("R2", "disabled irq keeps flag", 32'(sleep_flag), 32'd1);
      irq_en[2] = 1'b1;
      tick();
      irq[2] = 1'b0;
      chk("R2", "enabled irq clears flag", 32'(sleep_flag), 32'd0);
      sleep_strobe = 1'b1;
      tick();
      sleep_strobe = 1'b0;
      nmi = 1'b1;
      tick();
      nmi = 1'b0;
      chk("R2", "nmi clears flag", 32'(sleep_flag), 32'd0);
   endtask

   task automatic t_irq_wake();
      bus_hold_en = 1'b0;
      enter_standby();
      chk("R3", "srst in standby", 32'(per_srst), 32'h7);
      chk("R4", "bus floats", 32'(bus_hiz), 32'd1);
      bus_hold_en = 1'b1;
      tick();
      chk("R4", "bus held", 32'(bus_hiz), 32'd0);
      for (int k = 0; k < 4; k++) begin
         irq_en[5] = (k != 0); irq_stby_clr_en[5] = (k != 1);
         irq_cpu_mask[5] = (k == 2); irq_dtc_route[5] = (k == 3);
         irq[5] = 1'b1;
         tick();
         tick();
         irq[5] = 1'b0;
         chk("R5", $sformatf("blocked irq case %0d", k), 32'(state_o), 32'd1);
      end
      irq_en[5] = 1'b1; irq_stby_clr_en[5] = 1'b1;
      irq_cpu_mask[5] = 1'b0; irq_dtc_route[5] = 1'b0;
      settle_sel = 4'd0;
      irq[5] = 1'b1;
      tick();
      irq[5] = 1'b0;
      settle_sel = 4'd3;   // changing the code after the wake must not matter
      chk("R5", "qualified irq wakes", 32'(state_o), 32'd2);
      run_settle(0);
      bus_hold_en = 1'b0;
   endtask

   task automatic t_nmi_usb();
      enter_standby();
      settle_sel = 4'd1;
      nmi = 1'b1; irq_en = '0;
      tick();
      nmi = 1'b0;
      chk("R6", "nmi wakes", 32'(state_o), 32'd2);
      chk("R4", "bus floats in settle", 32'(bus_hiz), 32'd1);
      run_settle(1);
      enter_standby();
      settle_sel = 4'd2;
      usb_resume = 1'b1;
      tick();
      usb_resume = 1'b0;
      irq_en = '1;
      chk("R6", "usb resume wakes", 32'(state_o), 32'd2);
      run_settle(2);
   endtask

   task automatic t_reset_pin();
      enter_standby();
      res_pin_n = 1'b0;
      tick();
      chk("R9", "reset hold from standby", 32'(state_o), 32'd4);
      chk("R9", "clocks at once", {osc_en, cpu_clk_en, per_clk_en}, 3'b111);
      chk("R3", "srst in reset hold", 32'(per_srst), 32'h7);
      nmi = 1'b1;
      tick();
      nmi = 1'b0;
      chk("R9", "stays while low", {29'(state_o), rst_exc_req}, 32'd4 << 1);
      res_pin_n = 1'b1;
      tick();
      chk("R10", "run with reset req", {29'(state_o), rst_exc_req}, 32'd1);
      tick();
      chk("R10", "reset req ends", 32'(rst_exc_req), 32'd0);
   endtask

   task automatic t_hw_standby();
      enter_standby();
      hwstby_n = 1'b0; res_pin_n = 1'b0; nmi = 1'b1;
      tick();
      nmi = 1'b0;
      chk("R11", "hw standby", 32'(state_o), 32'd5);
      chk("R11", "all off", {osc_en, cpu_clk_en, per_clk_en, bus_hiz}, 4'b0001);
      hwstby_n = 1'b1;
      tick();
      chk("R12", "via reset hold", 32'(state_o), 32'd4);
      tick();
      chk("R12", "held by reset pin", 32'(state_o), 32'd4);
      res_pin_n = 1'b1;
      tick();
      chk("R12", "run after both high", {29'(state_o), rst_exc_req}, 32'd1);
      hwstby_n = 1'b0;
      tick();
      hwstby_n = 1'b1;
      chk("R11", "override from run", 32'(state_o), 32'd5);
      tick();
      chk("R12", "exit to reset hold", 32'(state_o), 32'd4);
      tick();
      chk("R12", "run with req", {29'(state_o), rst_exc_req}, 32'd1);
   endtask

   initial begin : p_watchdog
      repeat (200000) @(posedge clk_aon);
      if (!finished) begin
         vectors++;
         misses++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin : p_main
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_light_sleep();
      t_irq_wake();
      t_nmi_usb();
      t_reset_pin();
      t_hw_standby();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule